// File: doc/BRIEF.md
# Streaming Register Read Port

This block lets a small command processor read a run of consecutive configuration registers without issuing one address per word. The processor programs two values through its control-register write path: how many words it wants and the register index to begin at. From then on the block fetches ahead from the register space and offers one word at a time on a data output with a valid flag.

Consuming a word is an action in its own right. A pop while a word is valid takes that word, moves the index forward by one (wrapping past the top of the index space) and lowers the remaining count by one. When the count reaches zero the stream is over. A further pop returns zero, leaves the index alone and raises a one-cycle underflow flag. Writing either control value again throws away any word already held or in flight and restarts the fetch.

The register space is read through a simple synchronous port with one cycle of latency. By default the block issues the next read in the same cycle as the pop, so one word can be consumed every two cycles. The current index and remaining count are always visible on status outputs.

Top module: `srp_stream_read_port`

## Requirements
- R1: After reset the index and count are 0, `rvalid` and `underflow` are 0 and `rdata` is 0.
- R2: A control write with `ctl_wr_sel`=0 loads the count from the low 16 bits of `ctl_wr_data`, and one with `ctl_wr_sel`=1 loads the index from the low 16 bits. Each write leaves the other value unchanged.
- R3: While the count is nonzero, the word presented with `rvalid`=1 equals the register-space value at the current index. A register read (`rf_rd_en`=1) is only issued while the count is nonzero.
- R4: A pop while `rvalid`=1 makes the index one higher and the count one lower, both visible at the next clock edge.
- R5: With count 2 and index 0x08C1, two pops return registers 0x08C1 and 0x08C2, in that order. Afterwards the index is 0x08C3 and the count is 0.
- R6: The index wraps from 0xFFFF to 0x0000 as it advances.
- R7: A pop while the count is nonzero but `rvalid`=0 has no effect on the index or the count.
- R8: A pop while the count is 0 raises `underflow` for exactly one cycle, keeps `rdata` at 0 and leaves the index unchanged.
- R9: Writing the index again discards any held or in-flight word and fetches from the new index. The count is unchanged.
- R10: When a control write and a pop occur in the same cycle, the write takes effect and the pop is ignored.
- R11: `rdata` is 0 whenever `rvalid`=0. A valid word stays stable until it is popped or a control write occurs.
- R12: A stream of N words that no control write interrupts issues exactly N register reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ctl_wr_en | input | 1 | Control-register write strobe |
| ctl_wr_sel | input | 1 | 0 selects the count, 1 selects the start index |
| ctl_wr_data | input | 32 | Control write data |
| pop | input | 1 | Core consumes the current word |
| rdata | output | 32 | Current word, 0 when not valid |
| rvalid | output | 1 | `rdata` holds a word |
| underflow | output | 1 | One-cycle pulse after a pop at count zero |
| status_idx | output | 16 | Current register index |
| status_cnt | output | 16 | Remaining word count |
| rf_rd_en | output | 1 | Register-space read request |
| rf_rd_idx | output | 16 | Register-space read index |
| rf_rd_data | input | 32 | Register-space read data, one cycle after the request |

## Verification
The bench streams runs of several lengths, including the 0x08C1 case and a run that crosses 0xFFFF. A design that forgot to wrap or advanced twice would return the wrong register there. It pops too early, right after programming, and pops at count zero. A design that advanced on an unready pop would skip a register, and one that missed the zero check would corrupt the index or produce no underflow pulse. It rewrites the index while a read is in flight and collides a pop with a control write. A design that kept the stale in-flight word would present the old register, and one that let the pop win would lose the new count. It also counts register reads per stream, which exposes a prefetch that runs one read past the end.

// File: rtl/srp_pkg.sv
package srp_pkg;
  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_WAIT = 2'd1,
    FS_FULL = 2'd2
  } fetch_state_e;

  localparam logic SEL_COUNT = 1'b0;
  localparam logic SEL_BASE  = 1'b1;
endpackage

// File: rtl/srp_cursor.sv
// Holds the current register index and the remaining word count.
module srp_cursor #(
  parameter int IDX_W = 16,
  parameter int CNT_W = 16,
  parameter int CTL_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_cnt,
  input  logic             ld_idx,
  input  logic [CTL_W-1:0] wdata,
  input  logic             advance,
  output logic [IDX_W-1:0] idx,
  output logic [IDX_W-1:0] idx_next,
  output logic [CNT_W-1:0] cnt,
  output logic             cnt_zero,
  output logic             cnt_one
);
  logic [IDX_W-1:0] idx_q;
  logic [CNT_W-1:0] cnt_q;

  assign idx_next = IDX_W'(idx_q + 1'b1);
  assign idx      = idx_q;
  assign cnt      = cnt_q;
  assign cnt_zero = (cnt_q == '0);
  assign cnt_one  = (cnt_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= '0;
    end else if (ld_idx) begin
      idx_q <= wdata[IDX_W-1:0];
    end else if (advance) begin
      idx_q <= idx_next;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (ld_cnt) begin
      cnt_q <= wdata[CNT_W-1:0];
    end else if (advance && !cnt_zero) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/srp_fetch.sv
// Prefetch state machine: issues register reads and tracks the held word.
module srp_fetch #(
  parameter int IDX_W = 16,
  parameter bit CHAIN = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             pop,
  input  logic             cnt_zero,
  input  logic             cnt_one,
  input  logic [IDX_W-1:0] idx,
  input  logic [IDX_W-1:0] idx_next,
  output logic             rd_en,
  output logic [IDX_W-1:0] rd_idx,
  output logic             capture,
  output logic             advance,
  output logic             uflow_set
);
  import srp_pkg::*;

  fetch_state_e st_q, st_d;
  logic         chain_rd;

  generate
    if (CHAIN) begin : g_chain
      assign chain_rd = !cnt_one;
    end else begin : g_nochain
      assign chain_rd = 1'b0;
    end
  endgenerate

  always_comb begin
    st_d      = st_q;
    rd_en     = 1'b0;
    rd_idx    = idx;
    capture   = 1'b0;
    advance   = 1'b0;
    uflow_set = pop && cnt_zero && !restart;
    unique case (st_q)
      FS_IDLE: begin
        if (!restart && !cnt_zero) begin
          rd_en = 1'b1;
          st_d  = FS_WAIT;
        end
      end
      FS_WAIT: begin
        if (restart) begin
          st_d = FS_IDLE;
        end else begin
          capture = 1'b1;
          st_d    = FS_FULL;
        end
      end
      FS_FULL: begin
        if (restart) begin
          st_d = FS_IDLE;
        end else if (pop) begin
          advance = 1'b1;
          if (chain_rd) begin
            rd_en  = 1'b1;
            rd_idx = idx_next;
            st_d   = FS_WAIT;
          end else begin
            st_d = FS_IDLE;
          end
        end
      end
      default: st_d = FS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= FS_IDLE;
    else     st_q <= st_d;
  end
endmodule

// File: rtl/srp_out.sv
// Registered output stage: data word, valid flag and underflow pulse.
module srp_out #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic              drop,
  input  logic              uflow_set,
  input  logic [DATA_W-1:0] rf_data,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid,
  output logic              underflow
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata     <= '0;
      rvalid    <= 1'b0;
      underflow <= 1'b0;
    end else begin
      underflow <= uflow_set;
      if (capture) begin
        rdata  <= rf_data;
        rvalid <= 1'b1;
      end else if (drop) begin
        rdata  <= '0;
        rvalid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/srp_stream_read_port.sv
module srp_stream_read_port #(
  parameter int IDX_W  = 16,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32,
  parameter int CTL_W  = 32,
  parameter bit CHAIN  = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_wr_en,
  input  logic              ctl_wr_sel,
  input  logic [CTL_W-1:0]  ctl_wr_data,
  input  logic              pop,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid,
  output logic              underflow,
  output logic [IDX_W-1:0]  status_idx,
  output logic [CNT_W-1:0]  status_cnt,
  output logic              rf_rd_en,
  output logic [IDX_W-1:0]  rf_rd_idx,
  input  logic [DATA_W-1:0] rf_rd_data
);
  import srp_pkg::*;

  logic             ld_cnt, ld_idx;
  logic             advance, capture, uflow_set;
  logic             cnt_zero, cnt_one;
  logic [IDX_W-1:0] idx_next;

  assign ld_cnt = ctl_wr_en && (ctl_wr_sel == SEL_COUNT);
  assign ld_idx = ctl_wr_en && (ctl_wr_sel == SEL_BASE);

  srp_cursor #(.IDX_W(IDX_W), .CNT_W(CNT_W), .CTL_W(CTL_W)) u_cursor (
    .clk      (clk),
    .rst      (rst),
    .ld_cnt   (ld_cnt),
    .ld_idx   (ld_idx),
    .wdata    (ctl_wr_data),
    .advance  (advance),
    .idx      (status_idx),
    .idx_next (idx_next),
    .cnt      (status_cnt),
    .cnt_zero (cnt_zero),
    .cnt_one  (cnt_one)
  );

  srp_fetch #(.IDX_W(IDX_W), .CHAIN(CHAIN)) u_fetch (
    .clk       (clk),
    .rst       (rst),
    .restart   (ctl_wr_en),
    .pop       (pop),
    .cnt_zero  (cnt_zero),
    .cnt_one   (cnt_one),
    .idx       (status_idx),
    .idx_next  (idx_next),
    .rd_en     (rf_rd_en),
    .rd_idx    (rf_rd_idx),
    .capture   (capture),
    .advance   (advance),
    .uflow_set (uflow_set)
  );

  srp_out #(.DATA_W(DATA_W)) u_out (
    .clk       (clk),
    .rst       (rst),
    .capture   (capture),
    .drop      (advance || ctl_wr_en),
    .uflow_set (uflow_set),
    .rf_data   (rf_rd_data),
    .rdata     (rdata),
    .rvalid    (rvalid),
    .underflow (underflow)
  );
endmodule

// File: rtl/srp_checker.sv
module srp_checker #(
  parameter int IDX_W  = 16,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              ctl_wr_en,
  input logic              pop,
  input logic [DATA_W-1:0] rdata,
  input logic              rvalid,
  input logic              underflow,
  input logic [IDX_W-1:0]  status_idx,
  input logic [CNT_W-1:0]  status_cnt,
  input logic              rf_rd_en
);
  AST_READ_NEEDS_COUNT: assert property (@(posedge clk) disable iff (rst)
    rf_rd_en |-> (status_cnt != '0)); // R3

  AST_POP_ADVANCES: assert property (@(posedge clk) disable iff (rst)
    (pop && rvalid && !ctl_wr_en) |=>
      (status_idx == IDX_W'($past(status_idx) + 1'b1)) &&
      (status_cnt == CNT_W'($past(status_cnt) - 1'b1))); // R4

  AST_UNREADY_POP_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (pop && !rvalid && !ctl_wr_en) |=> ($stable(status_idx) && $stable(status_cnt))); // R7

  AST_UNDERFLOW_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(underflow) |-> ($past(pop) && $past(status_cnt) == '0)); // R8

  AST_ZERO_WHEN_EMPTY: assert property (@(posedge clk) disable iff (rst)
    !rvalid |-> (rdata == '0)); // R11

  AST_WORD_HELD: assert property (@(posedge clk) disable iff (rst)
    (rvalid && !pop && !ctl_wr_en) |=> (rvalid && $stable(rdata))); // R11
endmodule

bind srp_stream_read_port srp_checker #(
  .IDX_W(IDX_W), .CNT_W(CNT_W), .DATA_W(DATA_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .ctl_wr_en  (ctl_wr_en),
  .pop        (pop),
  .rdata      (rdata),
  .rvalid     (rvalid),
  .underflow  (underflow),
  .status_idx (status_idx),
  .status_cnt (status_cnt),
  .rf_rd_en   (rf_rd_en)
);

// File: tb/srp_stream_read_port_test.sv
module srp_stream_read_port_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ctl_wr_en = 1'b0;
  logic        ctl_wr_sel = 1'b0;
  logic [31:0] ctl_wr_data = '0;
  logic        pop = 1'b0;
  logic [31:0] rdata;
  logic        rvalid, underflow;
  logic [15:0] status_idx, status_cnt;
  logic        rf_rd_en;
  logic [15:0] rf_rd_idx;
  logic [31:0] rf_rd_data;

  int n_checks = 0;
  int n_fail   = 0;
  int rd_count = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  srp_stream_read_port uut (
    .clk(clk), .rst(rst), .ctl_wr_en(ctl_wr_en), .ctl_wr_sel(ctl_wr_sel),
    .ctl_wr_data(ctl_wr_data), .pop(pop), .rdata(rdata), .rvalid(rvalid),
    .underflow(underflow), .status_idx(status_idx), .status_cnt(status_cnt),
    .rf_rd_en(rf_rd_en), .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data)
  );

  function automatic logic [31:0] rf_val(input logic [15:0] i);
    return {~i, i} ^ 32'h5A5A_0000;
  endfunction

  // Register-space model: one cycle of read latency
  always_ff @(posedge clk) begin
    if (rf_rd_en) begin
      rf_rd_data <= rf_val(rf_rd_idx);
      rd_count   <= rd_count + 1;
    end
  end

  // {start index, count, expected final index}
  localparam logic [47:0] VEC [0:3] = '{
    {16'h08C1, 16'd2, 16'h08C3},
    {16'h0000, 16'd1, 16'h0001},
    {16'hFFFE, 16'd3, 16'h0001},
    {16'h1234, 16'd5, 16'h1239}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic ctl_write(input logic sel, input logic [31:0] d, input logic with_pop = 1'b0);
    @(negedge clk);
    ctl_wr_en = 1'b1; ctl_wr_sel = sel; ctl_wr_data = d; pop = with_pop;
    @(negedge clk);
    ctl_wr_en = 1'b0; pop = 1'b0;
  endtask

  task automatic do_pop();
    @(negedge clk);
    pop = 1'b1;
    @(negedge clk);
    pop = 1'b0;
  endtask

  task automatic wait_valid(input string req);
    int n = 0;
    while (!rvalid && n < 10) begin
      @(negedge clk);
      n++;
    end
    check(rvalid, req, {31'd0, rvalid}, 32'd1);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(status_idx == 16'h0, "R1 idx", 32'(status_idx), 32'h0);
    check(status_cnt == 16'h0, "R1 cnt", 32'(status_cnt), 32'h0);
    check(!rvalid && rdata == 32'h0, "R1 rvalid/rdata", rdata, 32'h0);
    check(!underflow, "R1 underflow", {31'd0, underflow}, 32'h0);

    // Table-driven streams: R3 R4 R5 R6 R12
    for (int v = 0; v < 4; v++) begin
      logic [15:0] s_idx, s_cnt, s_fin, e_idx;
      int base_rd;
      s_idx = VEC[v][47:32]; s_cnt = VEC[v][31:16]; s_fin = VEC[v][15:0];
      ctl_write(1'b0, {16'hDEAD, s_cnt});
      ctl_write(1'b1, {16'hBEEF, s_idx});
      base_rd = rd_count;
      e_idx = s_idx;
      for (int w = 0; w < int'(s_cnt); w++) begin
        wait_valid("R3 valid");
        check(rdata == rf_val(e_idx), (v == 0) ? "R5 word" : "R3 word", rdata, rf_val(e_idx));
        do_pop();
        e_idx = e_idx + 16'd1;
        check(status_idx == e_idx, (v == 2) ? "R6 wrap idx" : "R4 idx", 32'(status_idx), 32'(e_idx));
        check(status_cnt == s_cnt - 16'(w + 1), "R4 cnt", 32'(status_cnt), 32'(s_cnt - 16'(w + 1)));
      end
      repeat (3) @(negedge clk);
      check(status_idx == s_fin, "R5 final idx", 32'(status_idx), 32'(s_fin));
      check(status_cnt == 16'h0, "R5 final cnt", 32'(status_cnt), 32'h0);
      check(rd_count - base_rd == int'(s_cnt), "R12 read count", 32'(rd_count - base_rd), 32'(s_cnt));
      check(!rvalid && rdata == 32'h0, "R11 empty after stream", rdata, 32'h0);
    end

    // R8 pop at count zero
    begin
      logic [15:0] hold;
      hold = status_idx;
      do_pop();
      check(underflow, "R8 underflow raised", {31'd0, underflow}, 32'h1);
      check(rdata == 32'h0, "R8 rdata zero", rdata, 32'h0);
      check(status_idx == hold, "R8 idx kept", 32'(status_idx), 32'(hold));
      @(negedge clk);
      check(!underflow, "R8 single pulse", {31'd0, underflow}, 32'h0);
    end

    // R7 pop before data is valid
    ctl_write(1'b0, 32'd2);
    ctl_write(1'b1, 32'h0040);
    do_pop();
    check(status_idx == 16'h0040, "R7 idx kept", 32'(status_idx), 32'h40);
    check(status_cnt == 16'd2, "R7 cnt kept", 32'(status_cnt), 32'd2);
    wait_valid("R7 valid");
    check(rdata == rf_val(16'h0040), "R7 word", rdata, rf_val(16'h0040));

    // R9 restart while the next read is in flight
    ctl_write(1'b0, 32'd3);
    ctl_write(1'b1, 32'h0100);
    wait_valid("R9 valid");
    check(rdata == rf_val(16'h0100), "R9 first word", rdata, rf_val(16'h0100));
    do_pop();
    ctl_write(1'b1, 32'h0200);
    check(status_cnt == 16'd2, "R9 cnt kept", 32'(status_cnt), 32'd2);
    check(status_idx == 16'h0200, "R2 idx load", 32'(status_idx), 32'h200);
    wait_valid("R9 valid new");
    check(rdata == rf_val(16'h0200), "R9 new word", rdata, rf_val(16'h0200));
    do_pop();
    wait_valid("R9 valid next");

    // R11 held word stays stable
    begin
      logic [31:0] held;
      held = rdata;
      repeat (3) @(negedge clk);
      check(rvalid && rdata == held, "R11 word held", rdata, held);
    end

    // R10 control write collides with pop; R2 count load keeps idx
    ctl_write(1'b0, 32'hABCD_0007, 1'b1);
    check(status_cnt == 16'd7, "R10 cnt from write", 32'(status_cnt), 32'd7);
    check(status_idx == 16'h0201, "R10 idx not advanced", 32'(status_idx), 32'h201);
    check(!rvalid && rdata == 32'h0, "R11 dropped on write", rdata, 32'h0);
    wait_valid("R10 valid");
    check(rdata == rf_val(16'h0201), "R10 word", rdata, rf_val(16'h0201));

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end
endmodule